// File: doc/BRIEF.md
# UART Register Front End with Watermark Interrupts

This block is the software-visible face of a simple UART. A host reaches it through a 32-bit register bus with a single-cycle strobe. Bytes arriving from the receive side of the line are pushed into an on-chip receive FIFO, and software drains them by reading a data register. A write to the transmit data register sends the low byte of the written word straight out on an outgoing byte stream. Serial shifting and baud generation sit outside this block. The divisor register only stores the value that the serialiser will use.

Besides the data path, the block holds four configuration registers: interrupt enable, transmit control, receive control and divisor. It also provides a read-only pending register that is worked out live from watermark count fields. A single interrupt line follows the enable bits together with the receive FIFO state.

Read data is combinational from the address during the strobe cycle. A read of the receive data register removes the byte at the clock edge that ends that cycle.

Top module: `uart_regfile_wm`

## Requirements
- R1: A read of offset 0x04 while the receive FIFO holds data returns the oldest byte in bits 7:0 with zeros above, and removes that byte at the end of the access.
- R2: A read of offset 0x04 while the receive FIFO is empty returns 0x80000000 (bit 31 is the empty flag) and changes no state.
- R3: Bit 1 of the pending register (offset 0x14) is 1 exactly when the number of bytes held in the receive FIFO is strictly greater than bits 18:16 of the receive control register (offset 0x0C).
- R4: Bit 0 of the pending register is 1 exactly when bits 18:16 of the transmit control register (offset 0x08) are non-zero.
- R5: The interrupt line is high when bit 0 of the interrupt-enable register (offset 0x10) is set, or when bit 1 of it is set and the receive FIFO is non-empty; otherwise it is low.
- R6: The receive FIFO holds 8 bytes. `rx_ready` is high only while it has space, and a byte offered while it is full is discarded.
- R7: After reset, the enable, transmit control, receive control and divisor registers read zero, the pending register reads zero, the receive FIFO is empty and the interrupt line is low.
- R8: A write to offset 0x00 puts bits 7:0 of the written word on `tx_byte` with `tx_valid` high for exactly the one cycle after the write; a read of offset 0x00 returns zero.
- R9: The registers at offsets 0x08, 0x0C, 0x10 and 0x18 read back the full 32-bit value last written; writes to the pending register have no effect.
- R10: A read of any offset other than 0x00 to 0x18 in steps of four returns zero, and a write there changes no register.
- R11: A receive-data read that removes a byte and an accepted incoming byte in the same cycle are both performed, so the FIFO occupancy stays unchanged and the byte order is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid during the strobe cycle |
| rx_valid | input | 1 | Incoming byte offered |
| rx_byte | input | 8 | Incoming byte |
| rx_ready | output | 1 | FIFO has room; a byte is taken when valid and ready |
| tx_valid | output | 1 | Outgoing byte present for one cycle |
| tx_byte | output | 8 | Outgoing byte |
| irq | output | 1 | Interrupt line |

## Verification
The receive FIFO can be popped by a bus read and pushed by the incoming stream in the same clock edge. The bench sets up this collision by raising `rx_valid` in the same cycle as a strobed read of offset 0x04, with three bytes already queued. It then checks three things: the read returned the oldest byte, the receive watermark bit still reflects three entries, and draining produces the two remaining old bytes followed by the new one. The full-FIFO case, where an offered byte must be refused, is checked separately by draining and confirming that the discarded byte never appears.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;
   localparam int unsigned BUS_W        = 32;
   localparam int unsigned BYTE_W       = 8;

   localparam int unsigned OFF_TXDATA   = 'h00;
   localparam int unsigned OFF_RXDATA   = 'h04;
   localparam int unsigned OFF_TXCTRL   = 'h08;
   localparam int unsigned OFF_RXCTRL   = 'h0C;
   localparam int unsigned OFF_INTEN    = 'h10;
   localparam int unsigned OFF_PEND     = 'h14;
   localparam int unsigned OFF_DIVISOR  = 'h18;

   localparam int unsigned BIT_TXWM     = 0;
   localparam int unsigned BIT_RXWM     = 1;

   localparam logic [BUS_W-1:0] RX_EMPTY_WORD = 32'h8000_0000;

   typedef enum logic [2:0] {
      SEL_NONE, SEL_TXDATA, SEL_RXDATA, SEL_TXCTRL,
      SEL_RXCTRL, SEL_INTEN, SEL_PEND, SEL_DIVISOR
   } reg_sel_e;
endpackage

// File: rtl/uart_rf_rxfifo.sv
module uart_rf_rxfifo #(
   parameter int unsigned DEPTH = 8,
   parameter int unsigned WIDTH = 8,
   localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] wdata,
   input  logic             pop,
   output logic [WIDTH-1:0] rdata,
   output logic [CW-1:0]    count,
   output logic             full,
   output logic             empty
);
   localparam bit POW2 = (DEPTH == (1 << PW));

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PW-1:0]    rd_ptr, wr_ptr;
   logic [PW-1:0]    rd_next, wr_next;
   logic             do_push, do_pop;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("uart_rf_rxfifo: DEPTH must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("uart_rf_rxfifo: WIDTH must be at least 1");
      end
   endgenerate

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign rdata   = mem[rd_ptr];

   generate
      if (POW2) begin : g_wrap_free
         assign rd_next = rd_ptr + 1'b1;
         assign wr_next = wr_ptr + 1'b1;
      end else begin : g_wrap_cmp
         assign rd_next = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
         assign wr_next = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_next;
         if (do_pop)  rd_ptr <= rd_next;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/uart_rf_wm.sv
module uart_rf_wm #(
   parameter int unsigned CNT_W = 3,
   parameter int unsigned OCC_W = 4
) (
   input  logic [CNT_W-1:0] tx_mark,
   input  logic [CNT_W-1:0] rx_mark,
   input  logic [OCC_W-1:0] rx_occ,
   input  logic             en_txwm,
   input  logic             en_rxwm,
   output logic             pend_txwm,
   output logic             pend_rxwm,
   output logic             irq
);
   localparam int unsigned CMP_W = (CNT_W > OCC_W) ? CNT_W : OCC_W;

   assign pend_txwm = (tx_mark != '0);
   assign pend_rxwm = CMP_W'(rx_occ) > CMP_W'(rx_mark);
   assign irq       = en_txwm || (en_rxwm && (rx_occ != '0));
endmodule

// File: rtl/uart_regfile_wm.sv
module uart_regfile_wm
   import uart_rf_pkg::*;
#(
   parameter int unsigned ADDR_W     = 5,
   parameter int unsigned FIFO_DEPTH = 8,
   parameter int unsigned CNT_W      = 3,
   parameter int unsigned CNT_LSB    = 16,
   localparam int unsigned OCC_W     = $clog2(FIFO_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              rx_valid,
   input  logic [7:0]        rx_byte,
   output logic              rx_ready,
   output logic              tx_valid,
   output logic [7:0]        tx_byte,
   output logic              irq
);
   generate
      if (ADDR_W < 5) begin : g_bad_addr
         $error("uart_regfile_wm: ADDR_W too small for the register map");
      end
      if (CNT_LSB + CNT_W > BUS_W) begin : g_bad_field
         $error("uart_regfile_wm: count field exceeds the register width");
      end
   endgenerate

   reg_sel_e           sel;
   logic [BUS_W-1:0]   inten_q, txctrl_q, rxctrl_q, div_q;
   logic [BYTE_W-1:0]  fifo_head;
   logic [OCC_W-1:0]   fifo_cnt;
   logic               fifo_full, fifo_empty;
   logic               rd_acc, wr_acc, fifo_push, fifo_pop;
   logic               pend_tx, pend_rx;
   logic [BUS_W-1:0]   pend_word;

   always_comb begin
      unique case (bus_addr)
         ADDR_W'(OFF_TXDATA):  sel = SEL_TXDATA;
         ADDR_W'(OFF_RXDATA):  sel = SEL_RXDATA;
         ADDR_W'(OFF_TXCTRL):  sel = SEL_TXCTRL;
         ADDR_W'(OFF_RXCTRL):  sel = SEL_RXCTRL;
         ADDR_W'(OFF_INTEN):   sel = SEL_INTEN;
         ADDR_W'(OFF_PEND):    sel = SEL_PEND;
         ADDR_W'(OFF_DIVISOR): sel = SEL_DIVISOR;
         default:              sel = SEL_NONE;
      endcase
   end

   assign rd_acc    = bus_sel && !bus_wr;
   assign wr_acc    = bus_sel && bus_wr;
   assign fifo_pop  = rd_acc && (sel == SEL_RXDATA) && !fifo_empty;
   assign fifo_push = rx_valid && !fifo_full;
   assign rx_ready  = !fifo_full;

   uart_rf_rxfifo #(
      .DEPTH (FIFO_DEPTH),
      .WIDTH (BYTE_W)
   ) u_rxfifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (fifo_push),
      .wdata (rx_byte),
      .pop   (fifo_pop),
      .rdata (fifo_head),
      .count (fifo_cnt),
      .full  (fifo_full),
      .empty (fifo_empty)
   );

   uart_rf_wm #(
      .CNT_W (CNT_W),
      .OCC_W (OCC_W)
   ) u_wm (
      .tx_mark   (txctrl_q[CNT_LSB +: CNT_W]),
      .rx_mark   (rxctrl_q[CNT_LSB +: CNT_W]),
      .rx_occ    (fifo_cnt),
      .en_txwm   (inten_q[BIT_TXWM]),
      .en_rxwm   (inten_q[BIT_RXWM]),
      .pend_txwm (pend_tx),
      .pend_rxwm (pend_rx),
      .irq       (irq)
   );

   always_comb begin
      pend_word           = '0;
      pend_word[BIT_TXWM] = pend_tx;
      pend_word[BIT_RXWM] = pend_rx;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         inten_q  <= '0;
         txctrl_q <= '0;
         rxctrl_q <= '0;
         div_q    <= '0;
      end else if (wr_acc) begin
         case (sel)
            SEL_TXCTRL:  txctrl_q <= bus_wdata;
            SEL_RXCTRL:  rxctrl_q <= bus_wdata;
            SEL_INTEN:   inten_q  <= bus_wdata;
            SEL_DIVISOR: div_q    <= bus_wdata;
            default:     ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_valid <= 1'b0;
         tx_byte  <= '0;
      end else begin
         tx_valid <= wr_acc && (sel == SEL_TXDATA);
         if (wr_acc && (sel == SEL_TXDATA)) tx_byte <= bus_wdata[BYTE_W-1:0];
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (rd_acc) begin
         case (sel)
            SEL_RXDATA:  bus_rdata = fifo_empty ? RX_EMPTY_WORD
                                                : {{(BUS_W-BYTE_W){1'b0}}, fifo_head};
            SEL_TXCTRL:  bus_rdata = txctrl_q;
            SEL_RXCTRL:  bus_rdata = rxctrl_q;
            SEL_INTEN:   bus_rdata = inten_q;
            SEL_PEND:    bus_rdata = pend_word;
            SEL_DIVISOR: bus_rdata = div_q;
            default:     bus_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/uart_rf_chk.sv
module uart_rf_chk #(
   parameter int unsigned ADDR_W     = 5,
   parameter int unsigned FIFO_DEPTH = 8,
   parameter int unsigned OCC_W      = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic [31:0]       bus_rdata,
   input logic              rx_valid,
   input logic              rx_ready,
   input logic              tx_valid,
   input logic [7:0]        tx_byte,
   input logic              irq,
   input logic [31:0]       inten_q,
   input logic [OCC_W-1:0]  fifo_cnt
);
   logic rx_read, tx_write;
   assign rx_read  = bus_sel && !bus_wr && (bus_addr == ADDR_W'('h04));
   assign tx_write = bus_sel && bus_wr && (bus_addr == ADDR_W'('h00));

   // R2: empty read yields the flag word and leaves the occupancy alone
   assert_empty_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_read && fifo_cnt == '0 && !rx_valid) |-> (bus_rdata == 32'h8000_0000));
   assert_empty_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_read && fifo_cnt == '0 && !rx_valid) |=> (fifo_cnt == '0));

   // R5: interrupt line against the enable bits and FIFO state
   assert_irq_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !irq |-> !inten_q[0]);
   assert_irq_rx_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (inten_q[1] && fifo_cnt != '0) |-> irq);

   // R6: never above depth, not ready when full
   assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_cnt <= OCC_W'(FIFO_DEPTH));
   assert_full_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_cnt == OCC_W'(FIFO_DEPTH)) |-> !rx_ready);

   // R8: transmit write produces a one-cycle byte
   assert_tx_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      tx_write |=> (tx_valid && tx_byte == $past(bus_wdata[7:0])));
   assert_tx_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_write |=> !tx_valid);

   // R11: simultaneous pop and push keep the occupancy
   assert_swap_keep_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_read && fifo_cnt != '0 && rx_valid && rx_ready) |=> $stable(fifo_cnt));
endmodule

bind uart_regfile_wm uart_rf_chk #(
   .ADDR_W     (ADDR_W),
   .FIFO_DEPTH (FIFO_DEPTH),
   .OCC_W      (OCC_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .rx_valid  (rx_valid),
   .rx_ready  (rx_ready),
   .tx_valid  (tx_valid),
   .tx_byte   (tx_byte),
   .irq       (irq),
   .inten_q   (inten_q),
   .fifo_cnt  (fifo_cnt)
);

// File: tb/uart_regfile_wm_tb.sv
`timescale 1ns/1ps
module uart_regfile_wm_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_byte = '0;
   logic        rx_ready, tx_valid, irq;
   logic [7:0]  tx_byte;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   uart_regfile_wm u_dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_ready(rx_ready),
      .tx_valid(tx_valid), .tx_byte(tx_byte), .irq(irq)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #2 d = bus_rdata;
      @(posedge clk);
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic push(input logic [7:0] b);
      @(negedge clk);
      rx_valid = 1'b1; rx_byte = b;
      @(posedge clk);
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   task automatic t_reset;
      logic [31:0] d;
      check("R7", "irq after reset", {31'b0, irq}, 0);
      check("R7", "rx_ready after reset", {31'b0, rx_ready}, 1);
      rd(5'h08, d); check("R7", "txctrl", d, 0);
      rd(5'h0C, d); check("R7", "rxctrl", d, 0);
      rd(5'h10, d); check("R7", "inten", d, 0);
      rd(5'h14, d); check("R7", "pending", d, 0);
      rd(5'h18, d); check("R7", "divisor", d, 0);
      rd(5'h04, d); check("R7", "fifo empty", d, 32'h8000_0000);
   endtask

   task automatic t_regs;
      logic [31:0] d;
      wr(5'h08, 32'hA5A0_0F0F); rd(5'h08, d); check("R9", "txctrl readback", d, 32'hA5A0_0F0F);
      wr(5'h0C, 32'h5A58_F0F0); rd(5'h0C, d); check("R9", "rxctrl readback", d, 32'h5A58_F0F0);
      wr(5'h18, 32'hDEAD_BEEF); rd(5'h18, d); check("R9", "divisor readback", d, 32'hDEAD_BEEF);
      wr(5'h10, 32'hFFFF_FFFC); rd(5'h10, d); check("R9", "inten readback", d, 32'hFFFF_FFFC);
      wr(5'h08, 32'h0); wr(5'h0C, 32'h0007_0000);
      wr(5'h14, 32'hFFFF_FFFF); rd(5'h14, d); check("R9", "pending ignores write", d, 0);
      wr(5'h10, 32'h0); wr(5'h0C, 32'h0);
   endtask

   task automatic t_tx;
      logic [31:0] d;
      wr(5'h00, 32'h1234_56A5);
      check("R8", "tx_valid after write", {31'b0, tx_valid}, 1);
      check("R8", "tx_byte", {24'b0, tx_byte}, 32'hA5);
      @(negedge clk);
      check("R8", "tx_valid one cycle", {31'b0, tx_valid}, 0);
      rd(5'h00, d); check("R8", "tx data reads zero", d, 0);
   endtask

   task automatic t_rx_order;
      logic [31:0] d;
      push(8'h11); push(8'h22); push(8'h33);
      rd(5'h04, d); check("R1", "first byte", d, 32'h11);
      rd(5'h04, d); check("R1", "second byte", d, 32'h22);
      rd(5'h04, d); check("R1", "third byte", d, 32'h33);
      rd(5'h04, d); check("R2", "empty flag", d, 32'h8000_0000);
      rd(5'h04, d); check("R2", "empty read again", d, 32'h8000_0000);
      push(8'h44);
      rd(5'h04, d); check("R2", "empty read left no trace", d, 32'h44);
   endtask

   task automatic t_full;
      logic [31:0] d;
      for (int i = 0; i < 8; i++) push(8'hB0 + 8'(i));
      check("R6", "rx_ready low when full", {31'b0, rx_ready}, 0);
      push(8'hEE);
      for (int i = 0; i < 8; i++) begin
         rd(5'h04, d); check("R6", "drain order", d, 32'hB0 + 32'(i));
      end
      rd(5'h04, d); check("R6", "extra byte discarded", d, 32'h8000_0000);
      check("R6", "rx_ready high after drain", {31'b0, rx_ready}, 1);
   endtask

   task automatic t_wm;
      logic [31:0] d;
      wr(5'h0C, 32'h0002_0000);
      push(8'h01); push(8'h02);
      rd(5'h14, d); check("R3", "two bytes, mark 2", d & 32'h2, 0);
      push(8'h03);
      rd(5'h14, d); check("R3", "three bytes, mark 2", d & 32'h2, 2);
      wr(5'h0C, 32'h0003_0000);
      rd(5'h14, d); check("R3", "three bytes, mark 3", d & 32'h2, 0);
      rd(5'h14, d); check("R4", "tx mark zero", d & 32'h1, 0);
      wr(5'h08, 32'h0005_0000);
      rd(5'h14, d); check("R4", "tx mark five", d & 32'h1, 1);
      wr(5'h08, 32'hFFF8_FFFF);
      rd(5'h14, d); check("R4", "only field counts", d & 32'h1, 0);
      wr(5'h08, 32'h0); wr(5'h0C, 32'h0);
      for (int i = 0; i < 3; i++) rd(5'h04, d);
   endtask

   task automatic t_irq;
      logic [31:0] d;
      wr(5'h10, 32'h2);
      check("R5", "rx enable, empty", {31'b0, irq}, 0);
      push(8'h5C);
      check("R5", "rx enable, data", {31'b0, irq}, 1);
      rd(5'h04, d);
      check("R5", "rx enable, drained", {31'b0, irq}, 0);
      wr(5'h10, 32'h1);
      check("R5", "tx enable", {31'b0, irq}, 1);
      wr(5'h10, 32'h0);
      check("R5", "no enable", {31'b0, irq}, 0);
   endtask

   task automatic t_unmapped;
      logic [31:0] d;
      wr(5'h18, 32'h0000_1234);
      wr(5'h1C, 32'hFFFF_FFFF);
      wr(5'h19, 32'hFFFF_FFFF);
      rd(5'h1C, d); check("R10", "read 0x1C", d, 0);
      rd(5'h02, d); check("R10", "read 0x02", d, 0);
      rd(5'h18, d); check("R10", "divisor untouched", d, 32'h0000_1234);
      rd(5'h10, d); check("R10", "inten untouched", d, 0);
      check("R10", "irq untouched", {31'b0, irq}, 0);
   endtask

   task automatic t_same_cycle;
      logic [31:0] d;
      push(8'hA1); push(8'hA2); push(8'hA3);
      wr(5'h0C, 32'h0002_0000);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 5'h04;
      rx_valid = 1'b1; rx_byte = 8'hA4;
      #2 d = bus_rdata;
      @(posedge clk);
      @(negedge clk);
      bus_sel = 1'b0; rx_valid = 1'b0;
      check("R11", "popped oldest", d, 32'hA1);
      rd(5'h14, d); check("R11", "occupancy still 3", d & 32'h2, 2);
      rd(5'h04, d); check("R11", "next A2", d, 32'hA2);
      rd(5'h04, d); check("R11", "next A3", d, 32'hA3);
      rd(5'h04, d); check("R11", "new byte last", d, 32'hA4);
      rd(5'h04, d); check("R11", "then empty", d, 32'h8000_0000);
      wr(5'h0C, 32'h0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_regs();
      t_tx();
      t_rx_order();
      t_full();
      t_wm();
      t_irq();
      t_unmapped();
      t_same_cycle();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule